// File: doc/BRIEF.md
# PCI Bridge Window Register Bank

This block is the control register bank of a host-to-PCI bridge. It holds the
settings that describe four address windows (a base, a size mask and a
translated base for each), a small control word and a parity-error mask. All
of these are 64-bit registers, but the block sits on a 32-bit register bus, so
every register is reached as two 32-bit halves through a single shared staging
register.

Writes are split into two steps. The lower half is written first and only lands
in the staging register. The upper-half write then merges with the staged value
and commits the full 64 bits. Reads mirror this: a lower-half read returns bits
31:0 and parks bits 63:32 in the staging register, and a following upper-half
read returns the parked word. Each register keeps only its own writable bits.
The control register also shows a constant bridge number and a fixed marker bit
on read. Accesses to an index with no register behind it are flagged with a
one-cycle strobe.

Top module: `pci_window_regbank`

## Requirements
- R1: A write with address bit 2 clear loads bus_wdata into the staging register and changes no stored register.
- R2: A write with address bit 2 set stores {bus_wdata, staging} into the register at index bus_addr[ADDR_W-1:6]. Address bits 5:3 and 1:0 play no part in decode.
- R3: A read with bit 2 clear returns bits 31:0 of the indexed register on bus_rdata in the next cycle and loads bits 63:32 into staging. A read with bit 2 set returns the staging word in the next cycle. bus_rdata holds its value in cycles with no read, and a write takes priority over a read given in the same cycle.
- R4: Window base indices 0, 1 and 2 keep only bits under 0x00000000_FFF00003. Window base index 3 keeps bits under 0xFFFFFF80_FFF00003.
- R5: Window mask indices 4 to 7 keep bits under 0xFFF00000. Translated base indices 8 to 11 keep bits under 0x7_FFFFFC00.
- R6: The control register at index 0x0C stores only bits 44, 6, 5 and 3. A read of it returns those bits, with BRIDGE_ID in bits 47:46 and a 1 in bit 40.
- R7: The error mask at index 0x10 keeps bits ERRMASK_W-1:0 and reads the rest as zero.
- R8: Index 0x0F (error status) and index 0x20 (bus reset request) read as zero, ignore writes, and do not raise the strobe.
- R9: Any other index reads as zero and ignores writes. acc_unhandled is high for exactly the cycle after a lower-half read or an upper-half write to such an index.
- R10: After reset every stored field, the staging register and bus_rdata are zero, and acc_unhandled is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address: bit 2 picks the half, bits ADDR_W-1:6 give the index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| acc_unhandled | output | 1 | One-cycle pulse for an access to an undefined index |

## Verification
The bench builds the block with BRIDGE_ID set to 2 and the default 12-bit address. With that value bit 47 is set and bit 46 is clear, so a swapped or shifted bridge field shows up on read. The six index bits reach the reset-request index 0x20 and the undefined indices up to 0x3F. Random 64-bit data with random filler in the ignored address bits exercises every register mask at each window slot, including the wider mask of the last window base.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int HALF_W       = 32;
  localparam int FULL_W       = 64;
  localparam int NUM_WIN      = 4;
  localparam int IDX_LSB      = 6;
  localparam int HALF_SEL_BIT = 2;

  typedef enum logic [2:0] {
    K_NONE, K_WBASE, K_WMASK, K_XLAT, K_CTRL, K_ERR, K_ERRMASK, K_SWRST
  } reg_kind_e;

  typedef struct packed {
    logic pte_verify;
    logic monarch_win;
    logic pci_hole;
    logic chain_off;
  } ctrl_t;

  localparam logic [FULL_W-1:0] KEEP_BASE_NARROW = 64'h0000_0000_FFF0_0003;
  localparam logic [FULL_W-1:0] KEEP_BASE_WIDE   = 64'hFFFF_FF80_FFF0_0003;
  localparam logic [FULL_W-1:0] KEEP_WMASK       = 64'h0000_0000_FFF0_0000;
  localparam logic [FULL_W-1:0] KEEP_XLAT        = 64'h0000_0007_FFFF_FC00;

  localparam int POS_PTE     = 44;
  localparam int POS_MONARCH = 6;
  localparam int POS_HOLE    = 5;
  localparam int POS_CHAIN   = 3;
  localparam int POS_MARKER  = 40;
  localparam int POS_ID      = 46;

  function automatic reg_kind_e kind_of(input logic [7:0] idx);
    reg_kind_e k;
    if (idx[7:2] == 6'd0)      k = K_WBASE;
    else if (idx[7:2] == 6'd1) k = K_WMASK;
    else if (idx[7:2] == 6'd2) k = K_XLAT;
    else if (idx == 8'h0C)     k = K_CTRL;
    else if (idx == 8'h0F)     k = K_ERR;
    else if (idx == 8'h10)     k = K_ERRMASK;
    else if (idx == 8'h20)     k = K_SWRST;
    else                       k = K_NONE;
    return k;
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [FULL_W-1:0] w);
    ctrl_t c;
    c.pte_verify  = w[POS_PTE];
    c.monarch_win = w[POS_MONARCH];
    c.pci_hole    = w[POS_HOLE];
    c.chain_off   = w[POS_CHAIN];
    return c;
  endfunction

  function automatic logic [FULL_W-1:0] ctrl_to_word(input ctrl_t c, input logic [1:0] id);
    logic [FULL_W-1:0] w;
    w              = '0;
    w[POS_PTE]     = c.pte_verify;
    w[POS_MONARCH] = c.monarch_win;
    w[POS_HOLE]    = c.pci_hole;
    w[POS_CHAIN]   = c.chain_off;
    w[POS_MARKER]  = 1'b1;
    w[POS_ID +: 2] = id;
    return w;
  endfunction
endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import rb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind,
  output logic [1:0]       slot
);
  always_comb begin
    kind = kind_of(8'(idx));
    slot = idx[1:0];
  end
endmodule

// File: rtl/rb_stage.sv
module rb_stage
  import rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [HALF_W-1:0] load_val,
  output logic [HALF_W-1:0] stage_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       stage_q <= '0;
    else if (load_en) stage_q <= load_val;
  end
endmodule

// File: rtl/rb_store.sv
module rb_store
  import rb_pkg::*;
#(
  parameter int         ERRMASK_W = 12,
  parameter logic [1:0] BRIDGE_ID = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_en,
  input  reg_kind_e         kind,
  input  logic [1:0]        slot,
  input  logic [FULL_W-1:0] wr_word,
  output logic [FULL_W-1:0] rd_word
);
  logic [FULL_W-1:0] base_arr [NUM_WIN];
  logic [FULL_W-1:0] wmask_arr [NUM_WIN];
  logic [FULL_W-1:0] xlat_arr [NUM_WIN];
  ctrl_t                ctrl_q;
  logic [ERRMASK_W-1:0] errmask_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [FULL_W-1:0] BKEEP =
      (w == NUM_WIN - 1) ? KEEP_BASE_WIDE : KEEP_BASE_NARROW;
    logic [FULL_W-1:0] b_q, m_q, x_q;
    logic hit;
    assign hit = commit_en && (slot == 2'(w));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        b_q <= '0;
        m_q <= '0;
        x_q <= '0;
      end else if (hit) begin
        if (kind == K_WBASE) b_q <= wr_word & BKEEP;
        if (kind == K_WMASK) m_q <= wr_word & KEEP_WMASK;
        if (kind == K_XLAT)  x_q <= wr_word & KEEP_XLAT;
      end
    end
    assign base_arr[w]  = b_q;
    assign wmask_arr[w] = m_q;
    assign xlat_arr[w]  = x_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      errmask_q <= '0;
    end else if (commit_en) begin
      if (kind == K_CTRL)    ctrl_q    <= ctrl_from_word(wr_word);
      if (kind == K_ERRMASK) errmask_q <= wr_word[ERRMASK_W-1:0];
    end
  end

  always_comb begin
    case (kind)
      K_WBASE:   rd_word = base_arr[slot];
      K_WMASK:   rd_word = wmask_arr[slot];
      K_XLAT:    rd_word = xlat_arr[slot];
      K_CTRL:    rd_word = ctrl_to_word(ctrl_q, BRIDGE_ID);
      K_ERRMASK: rd_word = FULL_W'(errmask_q);
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/pci_window_regbank.sv
module pci_window_regbank
  import rb_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         ERRMASK_W = 12,
  parameter logic [1:0] BRIDGE_ID = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              acc_unhandled
);
  localparam int IDX_W = ADDR_W - IDX_LSB;

  logic [IDX_W-1:0]  idx;
  logic              hi_half;
  reg_kind_e         kind;
  logic [1:0]        slot;
  logic              wr_lo, commit_en, rd_lo, rd_hi;
  logic              stage_load;
  logic [HALF_W-1:0] stage_val;
  logic [HALF_W-1:0] stage_q;
  logic [FULL_W-1:0] reg_word;
  logic              undef_hit;

  assign idx       = bus_addr[ADDR_W-1:IDX_LSB];
  assign hi_half   = bus_addr[HALF_SEL_BIT];
  assign wr_lo     = bus_wr && !hi_half;
  assign commit_en = bus_wr && hi_half;
  assign rd_lo     = bus_rd && !bus_wr && !hi_half;
  assign rd_hi     = bus_rd && !bus_wr && hi_half;

  rb_decode #(.IDX_W(IDX_W)) u_dec (
    .idx  (idx),
    .kind (kind),
    .slot (slot)
  );

  assign stage_load = wr_lo || rd_lo;
  assign stage_val  = wr_lo ? bus_wdata : reg_word[FULL_W-1:HALF_W];

  rb_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (stage_load),
    .load_val (stage_val),
    .stage_q  (stage_q)
  );

  rb_store #(.ERRMASK_W(ERRMASK_W), .BRIDGE_ID(BRIDGE_ID)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_en (commit_en),
    .kind      (kind),
    .slot      (slot),
    .wr_word   ({bus_wdata, stage_q}),
    .rd_word   (reg_word)
  );

  assign undef_hit = (commit_en || rd_lo) && (kind == K_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata     <= '0;
      acc_unhandled <= 1'b0;
    end else begin
      acc_unhandled <= undef_hit;
      if (rd_lo)      bus_rdata <= reg_word[HALF_W-1:0];
      else if (rd_hi) bus_rdata <= stage_q;
    end
  end
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int         ADDR_W    = 12,
  parameter logic [1:0] BRIDGE_ID = 2'd0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              acc_unhandled,
  input logic [31:0]       stage_q
);
  localparam int IDX_W = ADDR_W - 6;
  logic [IDX_W-1:0] cidx;
  logic             is_defined;
  assign cidx = bus_addr[ADDR_W-1:6];
  assign is_defined = (cidx < IDX_W'(13)) || (cidx == IDX_W'(15)) ||
                      (cidx == IDX_W'(16)) || (cidx == IDX_W'(32));

  p_stage_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[2]) |=> (stage_q == $past(bus_wdata)));

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_wr) |=> $stable(bus_rdata));

  p_hi_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr[2]) |=> (bus_rdata == $past(stage_q)));

  p_ctrl_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_addr[2] && cidx == IDX_W'(12)) |=>
    (stage_q[15:14] == BRIDGE_ID && stage_q[8]));

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_addr[2] && !is_defined) |=>
    (bus_rdata == 32'd0 && stage_q == 32'd0 && acc_unhandled));

  p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_unhandled |-> $past(((bus_wr && bus_addr[2]) ||
                             (bus_rd && !bus_wr && !bus_addr[2])) && !is_defined));
endmodule

bind pci_window_regbank rb_checker #(.ADDR_W(ADDR_W), .BRIDGE_ID(BRIDGE_ID)) u_rb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .acc_unhandled (acc_unhandled),
  .stage_q       (stage_q)
);

// File: tb/test_pci_window_regbank.sv
`timescale 1ns/1ps
module test_pci_window_regbank;
  localparam int         AW  = 12;
  localparam logic [1:0] BID = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          acc_unhandled;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [63:0] model [64];

  always #5 clk = ~clk;

  pci_window_regbank #(.ADDR_W(AW), .ERRMASK_W(12), .BRIDGE_ID(BID)) i_pci_window_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .acc_unhandled(acc_unhandled));

  function automatic logic [63:0] keep_of(input int idx);
    logic [63:0] lo_win;
    lo_win = {32'h0, 12'hFFF, 18'h0, 2'b11};
    if (idx < 3) return lo_win;
    if (idx == 3) return lo_win | {25'h1FF_FFFF, 39'h0};
    if (idx < 8) return {32'h0, 12'hFFF, 20'h0};
    if (idx < 12) return ((64'd1 << 35) - 64'd1) ^ ((64'd1 << 10) - 64'd1);
    if (idx == 12) return (64'd1 << 44) | (64'd1 << 6) | (64'd1 << 5) | (64'd1 << 3);
    if (idx == 16) return 64'hFFF;
    return 64'h0;
  endfunction

  function automatic bit defined(input int idx);
    return (idx <= 12) || idx == 15 || idx == 16 || idx == 32;
  endfunction

  function automatic logic [63:0] exp_read(input int idx);
    logic [63:0] v;
    v = model[idx];
    if (idx == 12) v = v | (64'(BID) << 46) | (64'd1 << 40);
    return v;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input int idx, input bit hi);
    logic [31:0] j;
    j = $urandom;
    return {idx[5:0], j[2:0], hi, j[4:3]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input bit hi, input logic [31:0] d, output logic strobe);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = mk_addr(idx, hi); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    strobe = acc_unhandled;
  endtask

  task automatic bus_read(input int idx, input bit hi, output logic [31:0] d, output logic strobe);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = mk_addr(idx, hi);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; strobe = acc_unhandled;
  endtask

  task automatic write64(input int idx, input logic [63:0] v, output logic strobe);
    logic s0;
    bus_write(idx, 1'b0, v[31:0], s0);
    bus_write(idx, 1'b1, v[63:32], strobe);
    if (defined(idx)) model[idx] = v & keep_of(idx);
  endtask

  task automatic read_check(input int idx, input string tag);
    logic [31:0] lo, hi; logic s0, s1; logic [63:0] e;
    e = exp_read(idx);
    bus_read(idx, 1'b0, lo, s0);
    bus_read(idx, 1'b1, hi, s1);
    check({hi, lo} == e, tag, {hi, lo}, e);
    check(s0 == !defined(idx), "R9 strobe on read", 64'(s0), 64'(!defined(idx)));
  endtask

  initial begin
    logic s; logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rdata == 0, "R10 rdata after reset", 64'(bus_rdata), 0);
    check(acc_unhandled == 0, "R10 strobe after reset", 64'(acc_unhandled), 0);
    read_check(3, "R10 window base 3 reset");
    read_check(12, "R10 control reset with fixed fields");
    read_check(16, "R10 error mask reset");

    write64(3, 64'hFFFF_FFFF_FFFF_FFFF, s);
    read_check(3, "R4 wide base mask");
    write64(1, 64'hFFFF_FFFF_FFFF_FFFF, s);
    read_check(1, "R4 narrow base mask");
    write64(6, 64'hFFFF_FFFF_FFFF_FFFF, s);
    read_check(6, "R5 window mask keep");
    write64(9, 64'hFFFF_FFFF_FFFF_FFFF, s);
    read_check(9, "R5 translated base keep");
    write64(12, 64'hFFFF_FFFF_FFFF_FFFF, s);
    read_check(12, "R6 control all ones");
    write64(16, 64'hFFFF_FFFF_FFFF_FFFF, s);
    read_check(16, "R7 error mask width");

    bus_write(12, 1'b0, 32'h0000_0000, s);
    read_check(12, "R1 low write leaves control");
    bus_write(7, 1'b0, 32'hA5A5_1234, s);
    bus_read(7, 1'b1, d, s);
    check(d == 32'hA5A5_1234, "R3 high read returns staged low write", 64'(d), 64'hA5A5_1234);

    bus_write(2, 1'b0, 32'hFFF0_0001, s);
    @(negedge clk); bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = mk_addr(2, 1'b1); bus_wdata = 32'h0;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    model[2] = 64'hFFF0_0001;
    check(bus_rdata == d, "R3 write wins over read", 64'(bus_rdata), 64'(d));
    read_check(2, "R2 commit of staged low half");

    write64(15, 64'hFFFF_FFFF_FFFF_FFFF, s);
    check(s == 0, "R8 no strobe on error status write", 64'(s), 0);
    read_check(15, "R8 error status reads zero");
    write64(32, 64'hFFFF_FFFF_FFFF_FFFF, s);
    check(s == 0, "R8 no strobe on reset request write", 64'(s), 0);
    read_check(32, "R8 reset request reads zero");
    read_check(12, "R8 control untouched by reset request");

    write64(17, 64'h1234_5678_9ABC_DEF0, s);
    check(s == 1, "R9 strobe on undefined write", 64'(s), 1);
    @(negedge clk);
    check(acc_unhandled == 0, "R9 strobe lasts one cycle", 64'(acc_unhandled), 0);
    read_check(17, "R9 undefined reads zero");
    read_check(0, "R9 undefined write left base 0");

    for (int it = 0; it < 400; it++) begin
      int widx, ridx; logic [63:0] v;
      widx = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 17);
      v = {$urandom, $urandom};
      write64(widx, v, s);
      check(s == !defined(widx), "R9 random write strobe", 64'(s), 64'(!defined(widx)));
      ridx = ($urandom % 2 == 0) ? widx : int'($urandom % 64);
      read_check(ridx, "R2 random write then read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule